// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level page table held in memory. A requester presents the virtual address together with the kind of access: a read or a write, and supervisor or user privilege. The walker then reads the first-level entry from the table whose frame is given on the base input. Next it reads the second-level (leaf) entry from the frame named by the first-level entry. It checks the leaf entry's valid and permission bits and answers with either a physical address or a fault code.

On a permitted access the walker marks the leaf entry as referenced. On a write it also marks the entry as modified. It stores the updated entry back to the same memory word, but only when one of those two status bits was not already set. The walker serves one request at a time. It talks to memory through a single request/acknowledge port that carries both reads and writes.

Page table entries are 32 bits wide:
- bits 31:12 hold the frame number
- bit 0 is valid
- bit 1 is read permission
- bit 2 is write permission
- bit 3 is user permission
- bit 4 is the referenced flag
- bit 5 is the modified flag

Fault codes are 0 for no fault, 1 for a missing page and 2 for a permission violation.

Top module: `pt_walker`

## Requirements
- R1: On a successful translation, `resp_paddr` is the leaf entry's frame number (entry bits 31:12) in bits 31:12, followed by the request's virtual address bits 11:0 unchanged.
- R2: The first memory access of every walk is a read at byte address {`pt_base_frame`, vaddr[31:22], 2'b00}.
- R3: When the first-level entry is valid, the second access is a read at {first-level entry bits 31:12, vaddr[21:12], 2'b00}.
- R4: If the first-level or the leaf entry has bit 0 clear, the response carries fault code 1 and `resp_paddr` = 0. An invalid first-level entry ends the walk after one read, and no memory write occurs.
- R5: A valid leaf yields fault code 2, with `resp_paddr` = 0 and no memory write, in these cases:
  - a read access to a leaf with bit 1 clear;
  - a write access to a leaf with bit 2 clear;
  - a user access (`req_user` = 1) to a leaf with bit 3 clear.
  A supervisor access ignores bit 3.
- R6: A permitted access writes back the leaf entry to the leaf read address, with bit 4 set. Bit 5 is also set when the access is a write. All other bits are kept.
- R7: The write-back of R6 happens only when it changes the entry. A walk whose leaf already holds the bits to be set makes exactly two reads and no write.
- R8: A request is taken only while `busy` is low. `busy` rises the cycle after acceptance and stays high until the cycle after the one-cycle `resp_valid` pulse. `req_valid` during a walk is ignored.
- R9: `mem_req` stays asserted, with `mem_addr`, `mem_we` and `mem_wdata` held steady, until the cycle in which `mem_ack` is seen high.
- R10: While `rst_n` is low at a clock edge, the next cycle shows `busy`, `resp_valid` and `mem_req` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pt_base_frame | input | 20 | Frame number of the first-level table |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = user privilege, 0 = supervisor |
| busy | output | 1 | Walk in progress |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_paddr | output | 32 | Translated physical address (0 on fault) |
| resp_fault | output | 2 | 0 none, 1 missing page, 2 permission violation |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write of `mem_wdata`, 0 = read |
| mem_addr | output | 32 | Byte address of the table entry |
| mem_wdata | output | 32 | Updated leaf entry |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory access complete |

## Verification
The main sweep crosses every combination of the leaf's three permission bits with all four access kinds (read or write, user or supervisor) and all four starting states of the referenced and modified flags. The sweep spreads indices and offsets so that misrouted address fields show up. It tells apart a permitted access from a permission fault, and a needed write-back from a redundant one, which exposes errors in the permission logic and in the change detection. Separate cases clear the valid bit at each level, to separate a first-level miss (one read) from a leaf miss (two reads). Further cases use the all-zero and all-one virtual addresses at the index boundaries, and a request raised mid-walk to confirm it is ignored. Memory latency varies from walk to walk so that the held-request handshake is exercised.

// File: rtl/pt_walker_pkg.sv
// Shared definitions for the page table walker: walk states, fault codes
// and the bit positions of the flag field in a table entry.
package pt_walker_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_READ,
        ST_L2_READ,
        ST_UPDATE,
        ST_DONE
    } walk_state_t;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_PAGE = 2'd1,
        FLT_PROT = 2'd2
    } fault_t;

    localparam int PTE_VALID = 0;
    localparam int PTE_RD    = 1;
    localparam int PTE_WR    = 2;
    localparam int PTE_USR   = 3;
    localparam int PTE_REF   = 4;
    localparam int PTE_MOD   = 5;

endpackage

// File: rtl/pt_addr_gen.sv
// Forms the byte address of a page table entry.
// First level: table frame from the base input, indexed by the upper VPN half.
// Second level: table frame from the first-level entry, indexed by the lower half.
// Assumes one table fills exactly one page, so OFF_W - IDX_W bits of byte
// select remain below the index.
module pt_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic [ADDR_W-OFF_W-1:0] base_frame,
    input  logic [ADDR_W-OFF_W-1:0] vpn,
    input  logic [ADDR_W-OFF_W-1:0] l1_frame,
    input  logic                    use_l2,
    output logic [ADDR_W-1:0]       entry_addr
);
    localparam int FRAME_W = ADDR_W - OFF_W;
    localparam int IDX_W   = FRAME_W / 2;
    localparam int SLOT_W  = OFF_W - IDX_W;

    // Select the table frame and index for the current level.
    always_comb begin
        if (use_l2) begin
            entry_addr = {l1_frame, vpn[IDX_W-1:0], {SLOT_W{1'b0}}};
        end else begin
            entry_addr = {base_frame, vpn[FRAME_W-1 -: IDX_W], {SLOT_W{1'b0}}};
        end
    end

endmodule

// File: rtl/pt_access_check.sv
// Judges a leaf entry against the requested access and builds the entry
// with its referenced/modified flags set.
// Assumes the valid bit is tested separately by the caller.
module pt_access_check #(
    parameter int PTE_W = 32
) (
    input  logic [PTE_W-1:0] pte,
    input  logic             is_write,
    input  logic             is_user,
    output logic             allowed,
    output logic [PTE_W-1:0] pte_upd,
    output logic             changed
);
    import pt_walker_pkg::*;

    // Permission test: the kind-specific right, plus the user right for user accesses.
    always_comb begin
        allowed = (is_write ? pte[PTE_WR] : pte[PTE_RD]) && (!is_user || pte[PTE_USR]);
    end

    // Status update and detection of whether it alters the stored entry.
    always_comb begin
        pte_upd          = pte;
        pte_upd[PTE_REF] = 1'b1;
        if (is_write) begin
            pte_upd[PTE_MOD] = 1'b1;
        end
        changed = (pte_upd != pte);
    end

endmodule

// File: rtl/pt_walker.sv
// Two-level page table walker. Takes one translation at a time, reads the
// first-level and leaf entries over a request/acknowledge memory port,
// checks validity and rights, and stores the leaf back only when its
// referenced/modified flags change.
// Assumes memory holds mem_rdata valid in the cycle mem_ack is high, and
// that mem_ack is a single-cycle answer to a held mem_req.
module pt_walker #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-OFF_W-1:0] pt_base_frame,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_vaddr,
    input  logic                    req_write,
    input  logic                    req_user,
    output logic                    busy,
    output logic                    resp_valid,
    output logic [ADDR_W-1:0]       resp_paddr,
    output logic [1:0]              resp_fault,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [ADDR_W-1:0]       mem_wdata,
    input  logic [ADDR_W-1:0]       mem_rdata,
    input  logic                    mem_ack
);
    import pt_walker_pkg::*;

    localparam int FRAME_W = ADDR_W - OFF_W;

    walk_state_t          state;
    logic [ADDR_W-1:0]    vaddr_q;
    logic                 write_q;
    logic                 user_q;
    logic [FRAME_W-1:0]   l1_frame_q;
    logic [ADDR_W-1:0]    pte_q;
    logic [ADDR_W-1:0]    paddr_q;
    fault_t               fault_q;

    logic                 leaf_ok;
    logic [ADDR_W-1:0]    leaf_upd;
    logic                 leaf_changed;

    pt_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
        .base_frame (pt_base_frame),
        .vpn        (vaddr_q[ADDR_W-1:OFF_W]),
        .l1_frame   (l1_frame_q),
        .use_l2     (state != ST_L1_READ),
        .entry_addr (mem_addr)
    );

    pt_access_check #(.PTE_W(ADDR_W)) u_check (
        .pte      (mem_rdata),
        .is_write (write_q),
        .is_user  (user_q),
        .allowed  (leaf_ok),
        .pte_upd  (leaf_upd),
        .changed  (leaf_changed)
    );

    // Output decode from the walk state.
    always_comb begin
        busy       = (state != ST_IDLE);
        resp_valid = (state == ST_DONE);
        mem_req    = (state == ST_L1_READ) || (state == ST_L2_READ) || (state == ST_UPDATE);
        mem_we     = (state == ST_UPDATE);
        mem_wdata  = pte_q;
        resp_paddr = paddr_q;
        resp_fault = fault_q;
    end

    // Walk sequencer: accept, read both levels, judge, optionally store back, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            vaddr_q    <= '0;
            write_q    <= 1'b0;
            user_q     <= 1'b0;
            l1_frame_q <= '0;
            pte_q      <= '0;
            paddr_q    <= '0;
            fault_q    <= FLT_NONE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        vaddr_q <= req_vaddr;
                        write_q <= req_write;
                        user_q  <= req_user;
                        paddr_q <= '0;
                        fault_q <= FLT_NONE;
                        state   <= ST_L1_READ;
                    end
                end
                ST_L1_READ: begin
                    if (mem_ack) begin
                        if (!mem_rdata[PTE_VALID]) begin
                            fault_q <= FLT_PAGE;
                            state   <= ST_DONE;
                        end else begin
                            l1_frame_q <= mem_rdata[ADDR_W-1:OFF_W];
                            state      <= ST_L2_READ;
                        end
                    end
                end
                ST_L2_READ: begin
                    if (mem_ack) begin
                        if (!mem_rdata[PTE_VALID]) begin
                            fault_q <= FLT_PAGE;
                            state   <= ST_DONE;
                        end else if (!leaf_ok) begin
                            fault_q <= FLT_PROT;
                            state   <= ST_DONE;
                        end else begin
                            paddr_q <= {mem_rdata[ADDR_W-1:OFF_W], vaddr_q[OFF_W-1:0]};
                            pte_q   <= leaf_upd;
                            state   <= leaf_changed ? ST_UPDATE : ST_DONE;
                        end
                    end
                end
                ST_UPDATE: begin
                    if (mem_ack) begin
                        state <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault == 2'd0) |-> resp_paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0]); // R1
    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault != 2'd0) |-> resp_paddr == '0); // R4
    AST_WB_REF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[PTE_REF] && mem_wdata[PTE_VALID])); // R6
    AST_WB_MOD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && write_q) |-> mem_wdata[PTE_MOD]); // R6
    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid); // R8
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy); // R8
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!busy && !resp_valid && !mem_req)); // R10

endmodule

// File: tb/pt_walker_test.sv
// Bench for pt_walker: sweeps leaf permissions, access kinds and initial
// status flags, plus invalid levels, index boundaries and mid-walk requests.
module pt_walker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] pt_base_frame = 20'h00100;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        busy;
    logic        resp_valid;
    logic [31:0] resp_paddr;
    logic [1:0]  resp_fault;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // memory model state and access log
    logic [31:0] mem_store [logic [31:0]];
    int          lat = 0;
    int          wait_cnt = 0;
    int          rd_cnt = 0;
    logic [31:0] rd_addr0 = '0;
    logic [31:0] rd_addr1 = '0;
    int          wr_cnt = 0;
    logic [31:0] wr_addr = '0;
    logic [31:0] wr_data = '0;

    pt_walker uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pt_base_frame (pt_base_frame),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .req_write     (req_write),
        .req_user      (req_user),
        .busy          (busy),
        .resp_valid    (resp_valid),
        .resp_paddr    (resp_paddr),
        .resp_fault    (resp_fault),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata),
        .mem_ack       (mem_ack)
    );

    always #4 clk = ~clk;

    // Memory responder with programmable latency; logs every access.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            mem_ack  <= 1'b0;
            wait_cnt <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wait_cnt >= lat) begin
                wait_cnt <= 0;
                mem_ack  <= 1'b1;
                if (mem_we) begin
                    mem_store[mem_addr] = mem_wdata;
                    wr_cnt  <= wr_cnt + 1;
                    wr_addr <= mem_addr;
                    wr_data <= mem_wdata;
                end else begin
                    mem_rdata <= mem_store.exists(mem_addr) ? mem_store[mem_addr] : 32'h0;
                    if (rd_cnt == 0) rd_addr0 <= mem_addr;
                    if (rd_cnt == 1) rd_addr1 <= mem_addr;
                    rd_cnt <= rd_cnt + 1;
                end
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        wait (cyc > 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        finish_run();
    end

    // Issue one request and wait for the response, sampled at the falling edge.
    task automatic walk(input logic [31:0] va, input logic w, input logic u,
                        output logic [31:0] pa, output logic [1:0] f, output logic got);
        int t = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        req_write = w;
        req_user  = u;
        @(negedge clk);
        req_valid = 1'b0;
        while (!resp_valid && t < 60) begin
            @(negedge clk);
            t++;
        end
        got = resp_valid;
        pa  = resp_paddr;
        f   = resp_fault;
    endtask

    // Build tables for one case, run it, and compare against computed expectations.
    task automatic do_case(input logic [31:0] va, input logic [2:0] rights, input logic w,
                           input logic u, input logic [1:0] ud, input logic l1v,
                           input logic l2v, input logic [19:0] leaf_frame,
                           input logic [19:0] tbl_frame);
        logic [31:0] l1a, l2a, l1e, l2e, newe, exp_pa, pa;
        logic [1:0]  exp_f, f;
        logic        allowed, exp_wb, got;
        l1a = {pt_base_frame, va[31:22], 2'b00};
        l2a = {tbl_frame, va[21:12], 2'b00};
        l1e = {tbl_frame, 11'h0, l1v};
        l2e = {leaf_frame, 6'h0, ud[1], ud[0], rights, l2v};
        mem_store[l1a] = l1e;
        mem_store[l2a] = l2e;
        rd_cnt = 0;
        wr_cnt = 0;
        allowed = (w ? rights[1] : rights[0]) && (!u || rights[2]);
        newe = l2e | 32'h10 | (w ? 32'h20 : 32'h0);
        if (!l1v || !l2v) exp_f = 2'd1;
        else if (!allowed) exp_f = 2'd2;
        else exp_f = 2'd0;
        exp_wb = (exp_f == 2'd0) && (newe != l2e);
        exp_pa = (exp_f == 2'd0) ? {leaf_frame, va[11:0]} : 32'h0;
        walk(va, w, u, pa, f, got);
        check(got, "R8 response", {31'h0, got}, 32'h1);
        // R4 and R5: fault code
        check(f == exp_f, exp_f == 2'd1 ? "R4 fault" : "R5 fault", {30'h0, f}, {30'h0, exp_f});
        // R1: translated address (0 on faults)
        check(pa == exp_pa, "R1 paddr", pa, exp_pa);
        // R2: first read address
        check(rd_addr0 == l1a, "R2 l1 addr", rd_addr0, l1a);
        if (l1v) begin
            check(rd_addr1 == l2a, "R3 l2 addr", rd_addr1, l2a);
            check(rd_cnt == 2, "R3 read count", rd_cnt, 2);
        end else begin
            check(rd_cnt == 1, "R4 read count", rd_cnt, 1);
        end
        // R7: store only on a real change
        check(wr_cnt == (exp_wb ? 1 : 0), "R7 write count", wr_cnt, exp_wb ? 1 : 0);
        if (exp_wb) begin
            check(wr_data == newe, "R6 wb data", wr_data, newe);
            check(wr_addr == l2a, "R6 wb addr", wr_addr, l2a);
        end
    endtask

    initial begin
        logic [31:0] pa;
        logic [1:0]  f;
        logic        got;
        repeat (3) @(negedge clk);
        // R10: outputs quiet while reset held
        check(!busy && !resp_valid && !mem_req, "R10 reset",
              {29'h0, busy, resp_valid, mem_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Main sweep: rights x access kind x initial flags.
        for (int n = 0; n < 128; n++) begin
            logic [31:0] va;
            va = {10'((n * 37) % 1024), 10'((n * 53 + 5) % 1024), 12'((n * 291) % 4096)};
            lat = n % 3;
            do_case(va, 3'(n / 16), n[3], n[2], n[1:0], 1'b1, 1'b1,
                    20'hA0000 ^ 20'(n * 977), 20'h00200 + 20'(n));
        end

        // Invalid entries at either level.
        for (int n = 0; n < 8; n++) begin
            lat = n % 3;
            do_case({10'(n * 100), 10'(n * 77), 12'(n * 500)}, 3'b111, n[0], n[1], 2'b00,
                    1'b0, 1'b1, 20'h12345, 20'h00300 + 20'(n));
            do_case({10'(n * 90 + 3), 10'(n * 61), 12'(n * 400)}, 3'b111, n[0], n[1], 2'b00,
                    1'b1, 1'b0, 20'h54321, 20'h00400 + 20'(n));
        end

        // Index boundaries; second case already has both flags set (no store, R7).
        lat = 1;
        do_case(32'hFFFF_FFFF, 3'b111, 1'b1, 1'b1, 2'b00, 1'b1, 1'b1, 20'hFFFFF, 20'h00500);
        do_case(32'h0000_0000, 3'b111, 1'b1, 1'b0, 2'b11, 1'b1, 1'b1, 20'h00001, 20'h00501);
        do_case(32'h0000_0FFF, 3'b001, 1'b0, 1'b0, 2'b01, 1'b1, 1'b1, 20'h0ABCD, 20'h00502);

        // R8: a request raised mid-walk is ignored.
        lat = 2;
        mem_store[{pt_base_frame, 10'h011, 2'b00}] = {20'h00600, 12'h001};
        mem_store[{20'h00600, 10'h022, 2'b00}] = {20'h0BEEF, 12'h033};
        rd_cnt = 0;
        wr_cnt = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = {10'h011, 10'h022, 12'h123};
        req_write = 1'b0;
        req_user  = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy, "R8 busy after accept", {31'h0, busy}, 32'h1);
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = 32'hDEAD_0000;
        @(negedge clk);
        req_valid = 1'b0;
        begin
            int t = 0;
            while (!resp_valid && t < 60) begin
                @(negedge clk);
                t++;
            end
        end
        check(resp_paddr == {20'h0BEEF, 12'h123}, "R8 first request served", resp_paddr,
              {20'h0BEEF, 12'h123});
        @(negedge clk);
        check(!busy, "R8 busy clears", {31'h0, busy}, 32'h0);
        repeat (8) @(negedge clk);
        check(rd_cnt == 2 && !busy, "R8 mid-walk request ignored", rd_cnt, 2);
        check(wr_cnt == 0, "R7 no store when unchanged", wr_cnt, 0);

        finish_run();
    end

endmodule